// File: doc/BRIEF.md
# Exhaustive Byte RAM Self-Test Sequencer

This block runs an exhaustive check of a small byte-wide RAM that sits at the bottom of the address space (page zero). One start pulse begins the sweep. At the current address the sequencer writes a pattern, reads it back and compares it, and only then moves on to the next pattern. The pattern counts upward from 0x00 to 0xFF. When every value has been verified at one address, the sweep moves to the next address, beginning at 0x00.

It drives a synchronous single-port RAM. The port has an address, write data, a write enable and a registered read-data return with one cycle of latency. Busy is high for the whole sweep. The sweep ends in one of two ways: pass, raised only after the last byte has been verified, or fail, raised at the first mismatch. On a fail the sequencer also holds the failing address and the pattern that was expected there. The defaults cover 128 bytes (addresses 0x00 to 0x7F), which is 32,768 write-and-verify steps. The address width is a parameter.

Top module: `byte_sweep_bist`

## Requirements
- R1: After reset, busy, pass, fail and memWe are all low.
- R2: A start pulse while idle raises busy on the next cycle and clears pass and fail. The first write goes to address 0 with data 0x00.
- R3: Write k of a sweep (counting from 0) goes to address k/256 with data k mod 256. The pattern rises from 0x00 to 0xFF before the address increments.
- R4: Each write is followed in the next cycle by a read of the same address with memWe low. The read data is compared in the cycle after that.
- R5: A fault-free sweep keeps busy high for exactly 3 × 256 × DEPTH cycles. It makes DEPTH × 256 writes and ends with pass high and fail low.
- R6: On the first mismatch (address a, pattern p) the sweep stops. busy is high for exactly 3 × (256a + p + 1) cycles. Then fail is high, failAddr = a and failPattern = p.
- R7: pass and fail are never high together. Both hold their value while idle until the next start.
- R8: A start pulse while busy has no effect: the sweep length and result are unchanged.
- R9: memWe is never high while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that launches a sweep |
| memAddr | output | ADDR_W | RAM address |
| memWdata | output | DATA_W | RAM write data (current pattern) |
| memWe | output | 1 | RAM write enable |
| memRdata | input | DATA_W | RAM read data, valid one cycle after the address |
| busy | output | 1 | Sweep in progress |
| pass | output | 1 | Last sweep verified every byte |
| fail | output | 1 | Last sweep hit a mismatch |
| failAddr | output | ADDR_W | Address of the first mismatch |
| failPattern | output | DATA_W | Pattern expected at the first mismatch |

## Verification
The assertions assume the RAM returns the addressed word exactly one cycle after a read cycle. They also assume start is a clean synchronous pulse. The bench models the RAM with a one-cycle registered read and injects faults only as stuck-at bit masks on one address, applied at write time, so that read latency is always honoured. Start pulses are driven at falling edges and last one cycle. Some are placed deliberately in the middle of a sweep.

// File: rtl/byte_sweep_pkg.sv
package byte_sweep_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;     // reset counters at sweep launch
    logic writeEn;   // write current pattern to current address
    logic advance;   // step pattern, and address on pattern wrap
    logic latchFail; // capture address and pattern of a mismatch
  } sweepCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_CHECK = 2'd3
  } sweepState_t;

endpackage

// File: rtl/byte_sweep_dp.sv
module byte_sweep_dp
  import byte_sweep_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sweepCtl_t         ctl,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              mismatch,
  output logic              isLast,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failPattern
);

  localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};
  localparam logic [DATA_W-1:0] PAT_MAX  = {DATA_W{1'b1}};

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] patQ;
  logic              patWrap;

  assign patWrap  = (patQ == PAT_MAX);
  assign isLast   = patWrap && (addrQ == ADDR_MAX);
  assign mismatch = (memRdata != patQ);
  assign memAddr  = addrQ;
  assign memWdata = patQ;
  assign memWe    = ctl.writeEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      patQ  <= '0;
    end else if (ctl.clear) begin
      addrQ <= '0;
      patQ  <= '0;
    end else if (ctl.advance) begin
      patQ <= patQ + 1'b1;
      if (patWrap) addrQ <= addrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      failAddr    <= '0;
      failPattern <= '0;
    end else if (ctl.latchFail) begin
      failAddr    <= addrQ;
      failPattern <= patQ;
    end
  end

  // R2: a launch restarts both counters
  p_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (memAddr == '0) && (memWdata == '0));

  // R3: pattern steps within an address
  p_pat_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !patWrap) |=>
      (memWdata == DATA_W'($past(memWdata) + 1'b1)) && $stable(memAddr));

  // R3: address steps only on pattern wrap
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && patWrap) |=>
      (memWdata == '0) && (memAddr == ADDR_W'($past(memAddr) + 1'b1)));

  // R4: a write is followed by a read of the same location
  p_wr_then_rd_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe && $stable(memAddr) && $stable(memWdata));

  // R6: captured location matches the one under test
  p_latch_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latchFail |=> (failAddr == $past(memAddr)) && (failPattern == $past(memWdata)));

endmodule

// File: rtl/byte_sweep_ctrl.sv
module byte_sweep_ctrl
  import byte_sweep_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      mismatch,
  input  logic      isLast,
  output sweepCtl_t ctl,
  output logic      busy,
  output logic      pass,
  output logic      fail
);

  sweepState_t stateQ, stateD;

  always_comb begin
    ctl    = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          ctl.clear = 1'b1;
          stateD    = ST_WRITE;
        end
      end
      ST_WRITE: begin
        ctl.writeEn = 1'b1;
        stateD      = ST_READ;
      end
      ST_READ: begin
        stateD = ST_CHECK;
      end
      ST_CHECK: begin
        if (mismatch) begin
          ctl.latchFail = 1'b1;
          stateD        = ST_IDLE;
        end else if (isLast) begin
          stateD = ST_IDLE;
        end else begin
          ctl.advance = 1'b1;
          stateD      = ST_WRITE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      pass   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (ctl.clear) begin
        pass <= 1'b0;
        fail <= 1'b0;
      end else if (stateQ == ST_CHECK) begin
        if (mismatch)    fail <= 1'b1;
        else if (isLast) pass <= 1'b1;
      end
    end
  end

  assign busy = (stateQ != ST_IDLE);

  // R7: verdicts are exclusive
  p_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(pass && fail));

  // R7: verdicts hold while idle without a launch
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(pass) && $stable(fail));

  // R6: a fail ends the sweep
  p_fail_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fail) |-> !busy);

  // R5: pass only appears at the end of a sweep
  p_pass_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pass) |-> !busy && $past(busy));

  // R8: start in mid-sweep does not end it
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && (stateQ != ST_CHECK)) |=> busy);

  // R2: launch from idle makes the block busy
  p_launch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy && !pass && !fail);

endmodule

// File: rtl/byte_sweep_bist.sv
module byte_sweep_bist
  import byte_sweep_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              busy,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failPattern
);

  sweepCtl_t ctl;
  logic      mismatch;
  logic      isLast;

  byte_sweep_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .mismatch (mismatch),
    .isLast   (isLast),
    .ctl      (ctl),
    .busy     (busy),
    .pass     (pass),
    .fail     (fail)
  );

  byte_sweep_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .memWe       (memWe),
    .mismatch    (mismatch),
    .isLast      (isLast),
    .failAddr    (failAddr),
    .failPattern (failPattern)
  );

  // R9: no RAM writes outside a sweep
  p_we_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

endmodule

// File: tb/byte_sweep_bist_tb.sv
module byte_sweep_bist_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PATS       = 256;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0]        memWdata;
  logic              memWe;
  logic [7:0]        memRdata;
  logic              busy, pass, fail;
  logic [ADDR_W-1:0] failAddr;
  logic [7:0]        failPattern;

  int checks = 0;
  int fails  = 0;

  // Fault-injecting RAM model with one-cycle registered read
  logic [7:0]        ram [DEPTH];
  logic              faultOn = 1'b0;
  logic [ADDR_W-1:0] faultAt = '0;
  logic [7:0]        stuck1 = '0;
  logic [7:0]        stuck0 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_sweep_bist #(.ADDR_W(ADDR_W), .DATA_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRdata(memRdata),
    .busy(busy), .pass(pass), .fail(fail),
    .failAddr(failAddr), .failPattern(failPattern)
  );

  always @(posedge clk) begin
    if (memWe) begin
      if (faultOn && memAddr == faultAt) ram[memAddr] <= (memWdata | stuck1) & ~stuck0;
      else                               ram[memAddr] <= memWdata;
    end
    memRdata <= ram[memAddr];
  end

  // Bus monitor for R3, R4, R9
  int   wrCount = 0;
  int   seqErr  = 0;
  int   rdErr   = 0;
  int   idleWe  = 0;
  logic prevWe  = 1'b0;
  logic [ADDR_W-1:0] prevAddr = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (memWe && !busy) idleWe++;
      if (memWe) begin
        if (int'(memAddr) != wrCount / PATS || int'(memWdata) != wrCount % PATS) seqErr++;
        wrCount++;
      end else if (prevWe) begin
        if (memAddr != prevAddr) rdErr++;
      end
      if (prevWe && memWe) rdErr++;
      prevWe   = memWe;
      prevAddr = memAddr;
    end
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int firstBad(input logic [7:0] s1, input logic [7:0] s0);
    for (int p = 0; p < PATS; p++) begin
      logic [7:0] v;
      v = (8'(p) | s1) & ~s0;
      if (v != 8'(p)) return p;
    end
    return PATS;
  endfunction

  // Launch a sweep, optionally pulsing start again mid-sweep; returns busy cycles
  task automatic runSweep(input int extraAt, output int cycles);
    for (int i = 0; i < DEPTH; i++) ram[i] = 8'($urandom);
    wrCount = 0;
    seqErr  = 0;
    rdErr   = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (busy) begin
      cycles++;
      start = (cycles == extraAt) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  int cyc;
  int cycRef;

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", busy == 1'b0, busy, 0);
    check("R1 verdict", pass == 1'b0 && fail == 1'b0, {pass, fail}, 0);
    check("R1 memWe", memWe == 1'b0, memWe, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: launch raises busy next cycle, first write at address 0 data 0
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", busy == 1'b1, busy, 1);
    check("R2 first write", memWe && memAddr == 0 && memWdata == 0, {memWe, memWdata}, 256);
    while (busy) @(negedge clk);

    // R5: clean sweep
    runSweep(-1, cyc);
    cycRef = cyc;
    check("R5 busy length", cyc == 3 * PATS * DEPTH, cyc, 3 * PATS * DEPTH);
    check("R5 pass", pass == 1'b1 && fail == 1'b0, {pass, fail}, 2);
    check("R5 write count", wrCount == PATS * DEPTH, wrCount, PATS * DEPTH);
    check("R3 write order", seqErr == 0, seqErr, 0);
    check("R4 read after write", rdErr == 0, rdErr, 0);

    // R7: hold while idle
    repeat (20) @(negedge clk);
    check("R7 pass held", pass == 1'b1 && fail == 1'b0, {pass, fail}, 2);

    // R8: start while busy ignored (several positions)
    for (int k = 0; k < 3; k++) begin
      int at;
      at = (k == 0) ? 1 : int'($urandom_range(2, 3 * PATS * DEPTH - 2));
      runSweep(at, cyc);
      check("R8 length unchanged", cyc == cycRef, cyc, cycRef);
      check("R8 verdict unchanged", pass == 1'b1 && fail == 1'b0, {pass, fail}, 2);
    end

    // R6: directed and random stuck-at faults
    for (int k = 0; k < 5; k++) begin
      int expP;
      faultOn = 1'b1;
      if (k == 0) begin
        faultAt = '0; stuck1 = 8'h01; stuck0 = 8'h00;
      end else if (k == 1) begin
        faultAt = ADDR_W'(DEPTH - 1); stuck1 = 8'h00; stuck0 = 8'h80;
      end else begin
        faultAt = ADDR_W'($urandom_range(0, DEPTH - 1));
        stuck0  = 8'(1 << $urandom_range(0, 7));
        stuck1  = 8'($urandom) & ~stuck0;
      end
      expP = firstBad(stuck1, stuck0);
      runSweep(-1, cyc);
      check("R6 busy length", cyc == 3 * (PATS * int'(faultAt) + expP + 1),
            cyc, 3 * (PATS * int'(faultAt) + expP + 1));
      check("R6 fail flag", fail == 1'b1 && pass == 1'b0, {pass, fail}, 1);
      check("R6 fail address", failAddr == faultAt, failAddr, faultAt);
      check("R6 fail pattern", int'(failPattern) == expP, failPattern, expP);
      check("R3 order before fault", seqErr == 0, seqErr, 0);
      repeat (5) @(negedge clk);
      check("R7 fail held", fail == 1'b1 && pass == 1'b0, {pass, fail}, 1);
    end

    // R7: next start clears the old fail
    faultOn = 1'b0;
    runSweep(-1, cyc);
    check("R7 fail cleared by new sweep", pass == 1'b1 && fail == 1'b0, {pass, fail}, 2);
    check("R9 no idle writes", idleWe == 0, idleWe, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule